// File: doc/BRIEF.md
# Audio Stream Routing Crossbar

This block sits between four producers of stereo audio sample words and four consumers. The producers are DMA playback, DSP transmit, external input and the A/D converter. The consumers are external output, the D/A converter, DMA record and DSP receive. Each consumer picks its producer with a 2-bit code held in a byte-wide register bank. Sample words move over valid/ready streams, 16 bits per channel, with left and right packed into one word.

Handshaking can be dropped per path. A consumer with its bypass bit set takes words on valid alone. A producer with its bypass bit set is never held back. The DSP can be cut off from the crossbar on its transmit side and on its receive side. The register bank also holds a clock-select code for each producer. These codes are driven out to the clock logic, which lies outside the block.

A producer may feed several consumers. A word leaves the producer only when every live consumer listening to it is able to take it, and all of them take it in the same cycle. A new source code takes effect only when the consumer is not holding a stalled word, so a word is never split between two sources.

Top module: `audio_route_matrix`

## Requirements
- R1: After reset the register bank reads 0x01 at address 0, 0x11 at address 1, 0x00 at address 2 and 0x00 at address 3.
- R2: Bits with no function always read 0. The writable masks are 0x27 at address 0, 0xFF at address 1, 0x67 at address 2 and 0xFF at address 3.
- R3: A consumer outputs the data word of the producer its code selects. The codes are 0 = DMA playback, 1 = DSP transmit, 2 = external input and 3 = A/D converter. The code fields are:
  - external output: address 2, bits 2:1
  - D/A converter: address 2, bits 6:5
  - DMA record: address 3, bits 2:1
  - DSP receive: address 3, bits 6:5
- R4: With handshaking on, a producer is ready only when every live consumer selecting it is ready. A consumer shows valid only when its producer is valid and ready. A producer that no consumer selects is ready.
- R5: A consumer with its bypass bit set never stalls its producer and ignores its ready input. The bypass bits are address 2 bit 0 for external output, address 3 bit 0 for DMA record and address 3 bit 4 for DSP receive.
- R6: A producer with its bypass bit set has ready high at all times. The bypass bits are address 1 bit 0 for DMA playback, address 1 bit 4 for DSP transmit and address 0 bit 0 for external input.
- R7: When address 1 bit 7 is 0, the DSP transmit side is cut off. DSP transmit ready is low, and no consumer selecting code 1 shows valid.
- R8: When address 3 bit 7 is 0, DSP receive valid is low, and DSP receive does not stall its producer.
- R9: A new source code reaches a consumer one cycle after the write, unless the consumer is stalled. A stalled consumer keeps its old source until the pending word is taken.
- R10: The clock-select output carries a 2-bit code per producer, with DMA playback in the low bits. The codes come from these fields:
  - DMA playback: address 1 bits 2:1
  - DSP transmit: address 1 bits 6:5
  - external input: address 0 bits 2:1
  - A/D converter: address 0 bit 5, zero-extended
- R11: Address 1 bit 3 and address 3 bit 3 store the value written and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| src_valid_i | input | 4 | Producer valid, bit index equals source code |
| src_data_i | input | 4*SAMPLE_W | Producer words, producer s at bits s*SAMPLE_W |
| src_ready_o | output | 4 | Producer ready |
| dst_valid_o | output | 4 | Consumer valid (0 ext out, 1 D/A, 2 DMA rec, 3 DSP rec) |
| dst_data_o | output | 4*SAMPLE_W | Consumer words, consumer d at bits d*SAMPLE_W |
| dst_ready_i | input | 4 | Consumer ready |
| src_clk_sel_o | output | 8 | Clock-select codes, 2 bits per producer |

## Verification
The bench builds the block with the default SAMPLE_W of 32. Every producer carries its own pattern in both stereo halves, so routing from the wrong source shows up in either channel. With this width, the full register layout and all four consumers can be reached. The bench programs a mapping in which each producer feeds a different consumer, and one in which a producer fans out to two consumers. That makes the stall, bypass, cut-off and select-timing cases observable at the ports.

// File: rtl/audio_route_pkg.sv
package audio_route_pkg;
  localparam int unsigned N_SRC = 4;
  localparam int unsigned N_DST = 4;
  localparam int unsigned CODE_W = 2;
  localparam int unsigned N_REG = 4;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t SRC_DMA = 2'd0;
  localparam code_t SRC_DSP = 2'd1;
  localparam code_t SRC_EXT = 2'd2;
  localparam code_t SRC_ADC = 2'd3;

  localparam int unsigned DST_EXT = 0;
  localparam int unsigned DST_DAC = 1;
  localparam int unsigned DST_DMA = 2;
  localparam int unsigned DST_DSP = 3;

  localparam logic [7:0] RST_VAL [N_REG] = '{8'h01, 8'h11, 8'h00, 8'h00};
  localparam logic [7:0] WR_MASK [N_REG] = '{8'h27, 8'hFF, 8'h67, 8'hFF};
endpackage

// File: rtl/audio_route_regs.sv
module audio_route_regs
  import audio_route_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic [7:0] bank_o [N_REG]
);
  logic [7:0] bank_q [N_REG];

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          bank_q[i] <= RST_VAL[i];
      else if (we_i && addr_i == 2'(i))     bank_q[i] <= wdata_i & WR_MASK[i];
    end
    assign bank_o[i] = bank_q[i];
  end

  assign rdata_o = bank_q[addr_i];
endmodule

// File: rtl/audio_route_xbar.sv
module audio_route_xbar
  import audio_route_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  code_t                     sel_prog_i [N_DST],
  input  logic [N_DST-1:0]          dst_bypass_i,
  input  logic [N_DST-1:0]          dst_live_i,
  input  logic [N_SRC-1:0]          src_bypass_i,
  input  logic [N_SRC-1:0]          src_present_i,
  input  logic [N_SRC-1:0]          src_valid_i,
  input  logic [N_SRC*SAMPLE_W-1:0] src_data_i,
  output logic [N_SRC-1:0]          src_ready_o,
  output logic [N_DST-1:0]          dst_valid_o,
  output logic [N_DST*SAMPLE_W-1:0] dst_data_o,
  input  logic [N_DST-1:0]          dst_ready_i
);
  code_t            sel_act_q [N_DST];
  logic [N_DST-1:0] take;
  logic [N_DST-1:0] stall;

  assign take = dst_ready_i | dst_bypass_i;

  always_comb begin
    for (int s = 0; s < N_SRC; s++) begin
      logic all_take;
      all_take = 1'b1;
      for (int d = 0; d < N_DST; d++)
        if (dst_live_i[d] && sel_act_q[d] == code_t'(s)) all_take &= take[d];
      src_ready_o[s] = src_present_i[s] & (src_bypass_i[s] | all_take);
    end
  end

  for (genvar d = 0; d < N_DST; d++) begin : g_dst
    code_t s;
    assign s = sel_act_q[d];
    assign dst_valid_o[d] = dst_live_i[d] & src_valid_i[s] & src_ready_o[s];
    assign dst_data_o[d*SAMPLE_W +: SAMPLE_W] = src_data_i[s*SAMPLE_W +: SAMPLE_W];
    // pending word not yet taken by this consumer
    assign stall[d] = dst_live_i[d] & src_present_i[s] & src_valid_i[s] & ~take[d];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        sel_act_q[d] <= SRC_DMA;
      else if (!stall[d]) sel_act_q[d] <= sel_prog_i[d];
    end
  end
endmodule

// File: rtl/audio_route_matrix.sv
module audio_route_matrix
  import audio_route_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      reg_we_i,
  input  logic [1:0]                reg_addr_i,
  input  logic [7:0]                reg_wdata_i,
  output logic [7:0]                reg_rdata_o,
  input  logic [3:0]                src_valid_i,
  input  logic [4*SAMPLE_W-1:0]     src_data_i,
  output logic [3:0]                src_ready_o,
  output logic [3:0]                dst_valid_o,
  output logic [4*SAMPLE_W-1:0]     dst_data_o,
  input  logic [3:0]                dst_ready_i,
  output logic [7:0]                src_clk_sel_o
);
  logic [7:0] bank [N_REG];
  logic [7:0] src_hi_q, src_lo_q, dst_hi_q, dst_lo_q;

  audio_route_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .bank_o  (bank)
  );

  assign src_hi_q = bank[0];
  assign src_lo_q = bank[1];
  assign dst_hi_q = bank[2];
  assign dst_lo_q = bank[3];

  code_t            sel_prog [N_DST];
  logic [N_DST-1:0] dst_bypass, dst_live;
  logic [N_SRC-1:0] src_bypass, src_present;

  assign sel_prog[DST_EXT] = dst_hi_q[2:1];
  assign sel_prog[DST_DAC] = dst_hi_q[6:5];
  assign sel_prog[DST_DMA] = dst_lo_q[2:1];
  assign sel_prog[DST_DSP] = dst_lo_q[6:5];

  assign dst_bypass = {dst_lo_q[4], dst_lo_q[0], 1'b0, dst_hi_q[0]};
  assign dst_live   = {dst_lo_q[7], 3'b111};
  assign src_bypass = {1'b0, src_hi_q[0], src_lo_q[4], src_lo_q[0]};
  assign src_present = {2'b11, src_lo_q[7], 1'b1};

  assign src_clk_sel_o = {1'b0, src_hi_q[5], src_hi_q[2:1], src_lo_q[6:5], src_lo_q[2:1]};

  audio_route_xbar #(.SAMPLE_W(SAMPLE_W)) u_xbar (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sel_prog_i    (sel_prog),
    .dst_bypass_i  (dst_bypass),
    .dst_live_i    (dst_live),
    .src_bypass_i  (src_bypass),
    .src_present_i (src_present),
    .src_valid_i   (src_valid_i),
    .src_data_i    (src_data_i),
    .src_ready_o   (src_ready_o),
    .dst_valid_o   (dst_valid_o),
    .dst_data_o    (dst_data_o),
    .dst_ready_i   (dst_ready_i)
  );
endmodule

// File: rtl/audio_route_chk.sv
module audio_route_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] src_lo,
  input logic [7:0] dst_lo,
  input logic [1:0] reg_addr_i,
  input logic [7:0] reg_rdata_o,
  input logic [3:0] src_ready_o,
  input logic [3:0] dst_valid_o,
  input logic [3:0] dst_ready_i
);
  // R2
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd0 |-> (reg_rdata_o & 8'hD8) == 8'h00) and
    (reg_addr_i == 2'd2 |-> (reg_rdata_o & 8'h98) == 8'h00));

  // R6
  a_r6_dma_bypass_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_lo[0] |-> src_ready_o[0]);

  // R7
  a_r7_dsp_cut_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_lo[7] |-> !src_ready_o[1]);

  // R8
  a_r8_dsp_rec_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dst_lo[7] |-> !dst_valid_o[3]);

  // R5
  a_r5_dma_rec_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_lo[0] && !dst_ready_i[2] && dst_valid_o[2]) |-> src_lo[7] || dst_lo[2:1] != 2'd1);
endmodule

bind audio_route_matrix audio_route_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_lo      (src_lo_q),
  .dst_lo      (dst_lo_q),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .src_ready_o (src_ready_o),
  .dst_valid_o (dst_valid_o),
  .dst_ready_i (dst_ready_i)
);

// File: tb/audio_route_matrix_tb_top.sv
module audio_route_matrix_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [1:0]   reg_addr = '0;
  logic [7:0]   reg_wdata = '0;
  logic [7:0]   reg_rdata;
  logic [3:0]   src_valid = '0;
  logic [4*W-1:0] src_data;
  logic [3:0]   src_ready;
  logic [3:0]   dst_valid;
  logic [4*W-1:0] dst_data;
  logic [3:0]   dst_ready = '0;
  logic [7:0]   clk_sel;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  function automatic logic [W-1:0] sd(int s);
    return {16'hC000 + 16'(s), 16'h3000 + 16'(s) * 16'h0101};
  endfunction

  for (genvar s = 0; s < 4; s++) begin : g_sd
    assign src_data[s*W +: W] = sd(s);
  end

  audio_route_matrix dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .reg_we_i     (reg_we),
    .reg_addr_i   (reg_addr),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .src_valid_i  (src_valid),
    .src_data_i   (src_data),
    .src_ready_o  (src_ready),
    .dst_valid_o  (dst_valid),
    .dst_data_o   (dst_data),
    .dst_ready_i  (dst_ready),
    .src_clk_sel_o(clk_sel)
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    #1;
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(tag, W'(reg_rdata), W'(exp));
  endtask

  // each consumer fed by a different producer; DSP connected both sides
  task automatic cfg_distinct();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h80);
    wr(2'd2, 8'h46);   // ext out <- ADC, DAC <- ext in
    wr(2'd3, 8'h82);   // DMA rec <- DSP, DSP rec <- DMA
    step();
  endtask

  task automatic t_reset();
    rd_chk("R1 addr0", 2'd0, 8'h01);
    rd_chk("R1 addr1", 2'd1, 8'h11);
    rd_chk("R1 addr2", 2'd2, 8'h00);
    rd_chk("R1 addr3", 2'd3, 8'h00);
    chk("R10 reset clk sel", W'(clk_sel), W'(8'h00));
  endtask

  task automatic t_reserved();
    wr(2'd0, 8'hFF); rd_chk("R2 addr0 mask", 2'd0, 8'h27);
    wr(2'd2, 8'hFF); rd_chk("R2 addr2 mask", 2'd2, 8'h67);
    wr(2'd1, 8'hFF); rd_chk("R2 addr1 full", 2'd1, 8'hFF);
    wr(2'd1, 8'h08); rd_chk("R11 addr1 bit3", 2'd1, 8'h08);
    wr(2'd3, 8'h08); rd_chk("R11 addr3 bit3", 2'd3, 8'h08);
  endtask

  task automatic t_route();
    cfg_distinct();
    src_valid = 4'hF; dst_ready = 4'hF;
    #1;
    chk("R3 ext out <- ADC", dst_data[0*W +: W], sd(3));
    chk("R3 DAC <- ext in",  dst_data[1*W +: W], sd(2));
    chk("R3 DMA rec <- DSP", dst_data[2*W +: W], sd(1));
    chk("R3 DSP rec <- DMA", dst_data[3*W +: W], sd(0));
    chk("R3 all valid", W'(dst_valid), W'(4'hF));
    chk("R4 all ready", W'(src_ready), W'(4'hF));
  endtask

  task automatic t_backpressure();
    cfg_distinct();
    src_valid = 4'hF; dst_ready = 4'b1110;
    #1;
    chk("R4 ADC stalled", W'(src_ready[3]), W'(0));
    chk("R4 ext out no valid", W'(dst_valid[0]), W'(0));
    wr(2'd2, 8'h66);   // DAC <- ADC too; ext in has no listener
    step();
    dst_ready = 4'b1101;
    #1;
    chk("R4 fan-out stall", W'(src_ready[3]), W'(0));
    chk("R4 unlistened ready", W'(src_ready[2]), W'(1));
    dst_ready = 4'b1111;
    #1;
    chk("R4 fan-out both valid", W'(dst_valid[1:0]), W'(2'b11));
  endtask

  task automatic t_dst_bypass();
    cfg_distinct();
    wr(2'd2, 8'h47);
    src_valid = 4'hF; dst_ready = 4'b1110;
    #1;
    chk("R5 ADC ready despite ext out", W'(src_ready[3]), W'(1));
    chk("R5 ext out valid", W'(dst_valid[0]), W'(1));
  endtask

  task automatic t_src_bypass();
    cfg_distinct();
    wr(2'd0, 8'h01);
    src_valid = 4'hF; dst_ready = 4'b1101;
    #1;
    chk("R6 ext in ready", W'(src_ready[2]), W'(1));
  endtask

  task automatic t_dsp_cut();
    cfg_distinct();
    wr(2'd1, 8'h10);   // DSP bypass set, but cut off
    src_valid = 4'hF; dst_ready = 4'hF;
    #1;
    chk("R7 DSP ready low", W'(src_ready[1]), W'(0));
    chk("R7 DMA rec no valid", W'(dst_valid[2]), W'(0));
  endtask

  task automatic t_dsp_rec_off();
    cfg_distinct();
    wr(2'd3, 8'h02);
    src_valid = 4'hF; dst_ready = 4'b0111;
    #1;
    chk("R8 DSP rec no valid", W'(dst_valid[3]), W'(0));
    chk("R8 DMA play not stalled", W'(src_ready[0]), W'(1));
  endtask

  task automatic t_boundary();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h80);
    wr(2'd2, 8'h00);   // ext out and DAC <- DMA
    wr(2'd3, 8'hC2);
    step();
    src_valid = 4'hF; dst_ready = 4'b1110;
    wr(2'd2, 8'h04);   // ext out -> ext in while stalled
    step(); step();
    dst_ready = 4'hF;
    #1;
    chk("R9 stalled keeps old data", dst_data[0*W +: W], sd(0));
    chk("R9 stalled word valid", W'(dst_valid[0]), W'(1));
    step();
    chk("R9 switch after take", dst_data[0*W +: W], sd(2));
    wr(2'd2, 8'h06);
    chk("R9 one cycle latency", dst_data[0*W +: W], sd(2));
    step();
    chk("R9 new source applied", dst_data[0*W +: W], sd(3));
  endtask

  task automatic t_clk_sel();
    wr(2'd1, 8'hA4);
    wr(2'd0, 8'h26);
    chk("R10 clock selects", W'(clk_sel), W'(8'h76));
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_reserved();
    t_route();
    t_backpressure();
    t_dst_bypass();
    t_src_bypass();
    t_dsp_cut();
    t_dsp_rec_off();
    t_boundary();
    t_clk_sel();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule